// File: doc/BRIEF.md
# ADC Offset and Overrange Corrector

This block sits behind a 12-bit successive-approximation converter and turns each raw conversion code into the final output word. A signed user offset is held in a small register. The register is loaded through a parallel write port: a chip select, a write strobe and a 13-bit data word. When a conversion starts, the current offset is captured. When the conversion ends, the captured offset is added to the raw code.

The sum can be presented in two ways, chosen by a clip-enable level. With clipping on, the result is limited to the 12-bit range and bit 12 flags that the limit was hit. With clipping off, the whole sum is given as a 13-bit word. A negative sum is then given in two's complement. Because the sum always lies between -327 and 4422, the two ranges cannot be confused: codes 0 to 4422 are positive and codes 7865 to 8191 are negative.

Offset writes outside the legal range are refused and reported with a one-cycle error pulse. All logic runs on one clock. The reset is active low, and while it is held low the offset is kept at zero.

Top module: `adc_offset_corrector`

## Requirements
- R1: A write is taken when `wr_strobe` falls while `wr_cs_n` is low. If `wr_data[12:10]` is zero and `wr_data[9:0]` read as two's complement lies in -327..+327, that value becomes the stored offset. It applies to every conversion started after the write.
- R2: A write is refused if `wr_data[12:10]` is non-zero or if the 10-bit value lies outside -327..+327. The stored offset keeps its old value. `wr_err` is high for exactly one cycle: the cycle after the cycle in which the falling strobe was seen low.
- R3: A strobe fall while `wr_cs_n` is high changes nothing and raises no error.
- R4: While `rst_n` is low, the offset, the captured offset, `out_valid`, `out_word` and `wr_err` are all zero. After reset is released, conversions use offset zero until a write is made.
- R5: The offset is captured in the cycle where `conv_start` is high. A write that lands after that cycle does not change that conversion; it applies from the next one.
- R6: `out_valid` is high exactly one cycle after each cycle in which `raw_valid` is high, and low otherwise.
- R7: With clipping on and a sum (raw + offset) in 0..4095, `out_word[12]` is 0 and `out_word[11:0]` is the sum.
- R8: With clipping on, a sum above 4095 gives `out_word` = 0x1FFF and a sum below 0 gives `out_word` = 0x1000.
- R9: With clipping off, `out_word` is the sum as 13-bit two's complement. For example, 4095 + 256 gives 4351, and 0 + (-128) gives 8064.
- R10: `clip_en` is read only in the cycle where `raw_valid` is high. Its level at conversion start has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the offset |
| conv_start | input | 1 | One-cycle pulse at the start of a conversion; captures the offset |
| raw_code | input | 12 | Raw conversion result |
| raw_valid | input | 1 | One-cycle pulse when `raw_code` holds a finished result |
| wr_cs_n | input | 1 | Active-low select for offset writes |
| wr_strobe | input | 1 | Write strobe; its falling edge loads the word |
| wr_data | input | 13 | Offset write word |
| clip_en | input | 1 | 1 = clip to 12 bits with a range flag, 0 = full 13-bit sum |
| out_word | output | 13 | Corrected result |
| out_valid | output | 1 | Marks the cycle in which `out_word` holds a new result |
| wr_err | output | 1 | One-cycle pulse when an offset write is refused |

## Verification
A result is due one clock after its `raw_valid` cycle. An error pulse and a new stored offset are both due one clock after the cycle in which the low strobe is first seen. A captured offset takes effect at the edge that closes the `conv_start` cycle.

The bench's behavioural model advances on the same edges and is compared with the outputs at every falling clock edge. Timing slips of a single cycle therefore show up as mismatches. Directed tests also read each result at the falling edge just after its valid cycle, and check it against values worked out by hand for the offset and clip boundaries.

// File: rtl/adc_ofs_pkg.sv
package adc_ofs_pkg;
  localparam int RAW_W     = 12;
  localparam int OUT_W     = RAW_W + 1;
  localparam int OFS_W     = 10;
  localparam int OFS_LIMIT = 327;
  localparam int SUM_W     = RAW_W + 2;

  // true when the write word has zero pad bits and an in-range offset
  function automatic logic ofs_word_ok(input logic [OUT_W-1:0] w);
    logic signed [OFS_W-1:0] v;
    v = $signed(w[OFS_W-1:0]);
    return (w[OUT_W-1:OFS_W] == '0) &&
           (v >= -OFS_LIMIT) && (v <= OFS_LIMIT);
  endfunction

  // raw code plus signed offset, widened so no value can wrap
  function automatic logic signed [SUM_W-1:0] add_ofs(
      input logic [RAW_W-1:0] raw, input logic signed [OFS_W-1:0] ofs);
    logic signed [SUM_W-1:0] r;
    logic signed [SUM_W-1:0] o;
    r = $signed({2'b00, raw});
    o = $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
    return r + o;
  endfunction

  // final output word for either format
  function automatic logic [OUT_W-1:0] form_word(
      input logic signed [SUM_W-1:0] s, input logic clip);
    logic signed [SUM_W-1:0] top;
    top = $signed({2'b00, {RAW_W{1'b1}}});
    if (!clip)
      return s[OUT_W-1:0];
    else if (s > top)
      return {1'b1, {RAW_W{1'b1}}};
    else if (s < 0)
      return {1'b1, {RAW_W{1'b0}}};
    else
      return {1'b0, s[RAW_W-1:0]};
  endfunction
endpackage

// File: rtl/ofs_write_port.sv
module ofs_write_port
  import adc_ofs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    stb,
  input  logic [OUT_W-1:0]        din,
  output logic signed [OFS_W-1:0] ofs_q,
  output logic                    err
);
  logic stb_q;
  logic wr_fire;
  logic wr_ok;
  logic wr_reject;

  assign wr_fire   = stb_q && !stb && !cs_n;
  assign wr_ok     = ofs_word_ok(din);
  assign wr_reject = wr_fire && !wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      ofs_q <= '0;
      err   <= 1'b0;
    end else begin
      stb_q <= stb;
      err   <= wr_reject;
      if (wr_fire && wr_ok)
        ofs_q <= $signed(din[OFS_W-1:0]);
    end
  end

  // R1: stored offset never leaves the legal window
  a_r1_ofs_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_q >= -OFS_LIMIT) && (ofs_q <= OFS_LIMIT));
  // R2: a refused write leaves the register untouched
  a_r2_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(ofs_q));
  // R2: error pulse lasts a single cycle
  a_r2_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  // R3: without a selected strobe fall the register holds
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(ofs_q));
endmodule

// File: rtl/ofs_snapshot.sv
module ofs_snapshot
  import adc_ofs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [OFS_W-1:0] ofs_in,
  output logic signed [OFS_W-1:0] ofs_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ofs_act <= '0;
    else if (start)
      ofs_act <= ofs_in;
  end

  // R5: offset in use changes only at a conversion start
  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(ofs_act));
  a_r5_take_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ofs_act == $past(ofs_in)));
endmodule

// File: rtl/ofs_result_former.sv
module ofs_result_former
  import adc_ofs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [RAW_W-1:0]        raw,
  input  logic                    raw_valid,
  input  logic signed [OFS_W-1:0] ofs,
  input  logic                    clip_en,
  output logic [OUT_W-1:0]        word,
  output logic                    valid
);
  logic signed [SUM_W-1:0] sum;
  logic [OUT_W-1:0]        next_word;

  assign sum       = add_ofs(raw, ofs);
  assign next_word = form_word(sum, clip_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= raw_valid;
      if (raw_valid)
        word <= next_word;
    end
  end

  // R6: one result per strobe, exactly one cycle later
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid |=> valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |=> !valid);
  // R8: a flagged clipped word is saturated to one end
  a_r8_clip_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_valid && clip_en) |=>
      (!word[OUT_W-1] || word[RAW_W-1:0] == '1 || word[RAW_W-1:0] == '0));
endmodule

// File: rtl/adc_offset_corrector.sv
module adc_offset_corrector
  import adc_ofs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic [RAW_W-1:0] raw_code,
  input  logic             raw_valid,
  input  logic             wr_cs_n,
  input  logic             wr_strobe,
  input  logic [OUT_W-1:0] wr_data,
  input  logic             clip_en,
  output logic [OUT_W-1:0] out_word,
  output logic             out_valid,
  output logic             wr_err
);
  logic signed [OFS_W-1:0] ofs_stored;
  logic signed [OFS_W-1:0] ofs_active;

  ofs_write_port u_wr (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (wr_cs_n),
    .stb   (wr_strobe),
    .din   (wr_data),
    .ofs_q (ofs_stored),
    .err   (wr_err)
  );

  ofs_snapshot u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (conv_start),
    .ofs_in  (ofs_stored),
    .ofs_act (ofs_active)
  );

  ofs_result_former u_form (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw       (raw_code),
    .raw_valid (raw_valid),
    .ofs       (ofs_active),
    .clip_en   (clip_en),
    .word      (out_word),
    .valid     (out_valid)
  );

  // R2: an error never coincides with a result from an unrelated edge
  a_r2_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(!wr_strobe && !wr_cs_n));
endmodule

// File: tb/adc_offset_corrector_test.sv
`timescale 1ns/1ps
module adc_offset_corrector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic [11:0] raw_code = '0;
  logic        raw_valid = 1'b0;
  logic        wr_cs_n = 1'b1;
  logic        wr_strobe = 1'b0;
  logic [12:0] wr_data = '0;
  logic        clip_en = 1'b0;
  logic [12:0] out_word;
  logic        out_valid;
  logic        wr_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_offset_corrector uut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .raw_code(raw_code),
    .raw_valid(raw_valid), .wr_cs_n(wr_cs_n), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .clip_en(clip_en), .out_word(out_word),
    .out_valid(out_valid), .wr_err(wr_err)
  );

  // behavioural reference model, advanced on each rising edge
  integer m_off, m_snap, sum;
  bit     prev_stb, e_valid, e_err;
  integer e_word;
  string  e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_off = 0; m_snap = 0; prev_stb = 0;
      e_valid = 0; e_err = 0; e_word = 0; e_tag = "R4";
    end else begin
      e_valid = raw_valid;
      if (raw_valid) begin
        sum = raw_code + m_snap;
        if (clip_en) begin
          if (sum > 4095)   begin e_word = 8191; e_tag = "R8"; end
          else if (sum < 0) begin e_word = 4096; e_tag = "R8"; end
          else              begin e_word = sum;  e_tag = "R7"; end
        end else begin
          e_word = (sum < 0) ? sum + 8192 : sum;
          e_tag = "R9";
        end
      end
      if (conv_start) m_snap = m_off;
      e_err = 0;
      if (prev_stb && !wr_strobe && !wr_cs_n) begin
        integer v;
        v = wr_data[9] ? int'(wr_data[9:0]) - 1024 : int'(wr_data[9:0]);
        if (wr_data[12:10] == 0 && v >= -327 && v <= 327) m_off = v;
        else e_err = 1;
      end
      prev_stb = wr_strobe;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out_valid !== e_valid) begin
        failures++;
        $display("FAIL R6 out_valid actual=%0b expected=%0b", out_valid, e_valid);
      end
      if (e_valid) begin
        checks++;
        if (out_word !== e_word[12:0]) begin
          failures++;
          $display("FAIL %s out_word actual=%0d expected=%0d", e_tag, out_word, e_word);
        end
      end
      checks++;
      if (wr_err !== e_err) begin
        failures++;
        $display("FAIL R2 wr_err actual=%0b expected=%0b", wr_err, e_err);
      end
    end
  end

  task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] d, input logic cs, output logic err_seen);
    @(negedge clk); wr_cs_n = cs; wr_data = d; wr_strobe = 1'b1;
    @(negedge clk); wr_strobe = 1'b0;
    @(negedge clk); err_seen = wr_err; wr_cs_n = 1'b1;
  endtask

  task automatic conv(input logic [11:0] r, input logic c_start, input logic c_valid,
                      input bit mid, input logic [12:0] mid_d, output logic [12:0] got);
    logic e;
    @(negedge clk); conv_start = 1'b1; clip_en = c_start;
    @(negedge clk); conv_start = 1'b0; clip_en = 1'b0;
    if (mid) wr(mid_d, 1'b0, e);
    @(negedge clk); raw_code = r; raw_valid = 1'b1; clip_en = c_valid;
    @(negedge clk); raw_valid = 1'b0; clip_en = 1'b0; got = out_word;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [12:0] g;
    logic e;
    int unsigned seed;
    repeat (3) @(negedge clk);
    chk("R4 reset valid", {12'd0, out_valid}, 13'd0);
    chk("R4 reset word", out_word, 13'd0);
    chk("R4 reset err", {12'd0, wr_err}, 13'd0);
    rst_n = 1'b1;
    @(negedge clk);
    conv(12'd100, 0, 1, 0, 0, g); chk("R4 zero offset", g, 13'd100);
    wr(13'd256, 0, e); chk("R1 legal no err", {12'd0, e}, 13'd0);
    conv(12'd4095, 0, 0, 0, 0, g); chk("R1 R9 4095+256", g, 13'd4351);
    conv(12'd4095, 0, 1, 0, 0, g); chk("R8 over", g, 13'h1FFF);
    conv(12'd3000, 0, 1, 0, 0, g); chk("R7 in range", g, 13'd3256);
    wr(13'h0380, 0, e);
    conv(12'd0, 0, 0, 0, 0, g); chk("R9 negative", g, 13'd8064);
    conv(12'd0, 0, 1, 0, 0, g); chk("R8 under", g, 13'h1000);
    conv(12'd3838, 0, 1, 0, 0, g); chk("R7 shifted", g, 13'd3710);
    wr(13'd328, 0, e); chk("R2 range err", {12'd0, e}, 13'd1);
    conv(12'd1000, 0, 1, 0, 0, g); chk("R2 kept", g, 13'd872);
    wr(13'h1005, 0, e); chk("R2 pad err", {12'd0, e}, 13'd1);
    conv(12'd1000, 0, 1, 0, 0, g); chk("R2 kept pad", g, 13'd872);
    wr(13'd5, 1, e); chk("R3 no err", {12'd0, e}, 13'd0);
    conv(12'd1000, 0, 1, 0, 0, g); chk("R3 ignored", g, 13'd872);
    conv(12'd1000, 0, 1, 1, 13'd10, g); chk("R5 old offset", g, 13'd872);
    conv(12'd1000, 0, 1, 0, 0, g); chk("R5 new offset", g, 13'd1010);
    conv(12'd4095, 1, 0, 0, 0, g); chk("R10 clip at start", g, 13'd4105);
    conv(12'd4095, 0, 1, 0, 0, g); chk("R10 clip at valid", g, 13'h1FFF);
    wr(13'd327, 0, e);
    conv(12'd4095, 0, 0, 0, 0, g); chk("R1 max", g, 13'd4422);
    wr(13'd697, 0, e); chk("R1 min legal", {12'd0, e}, 13'd0);
    conv(12'd0, 0, 0, 0, 0, g); chk("R9 min", g, 13'd7865);
    wr(13'd696, 0, e); chk("R2 below min", {12'd0, e}, 13'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); chk("R4 mid valid", {12'd0, out_valid}, 13'd0);
    chk("R4 mid word", out_word, 13'd0);
    rst_n = 1'b1;
    conv(12'd50, 0, 0, 0, 0, g); chk("R4 offset cleared", g, 13'd50);
    seed = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      seed = seed * 1103515245 + 12345;
      if (seed[20]) begin
        int v;
        v = int'(seed[29:21] % 700) - 350;
        wr(seed[31] ? {seed[2:0], v[9:0]} : {3'b000, v[9:0]}, seed[30] & seed[3], e);
      end
      seed = seed * 1103515245 + 12345;
      conv(seed[27:16], seed[5], seed[6], seed[7], {3'b000, seed[9:0]}, g);
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule